// File: doc/BRIEF.md
# Multi-Width Level-Checked FIFO

This block is the 256-byte buffer that sits between a serial shifter and the software-visible data port of a serial peripheral. It serves as either the transmit or the receive buffer. Each push or pop moves one entry, and an entry is 1, 2 or 4 bytes wide, chosen at run time by a width code. Storage is counted in bytes, so the number of entries the buffer holds depends on the width in force.

A small operation interface has two controls. One clears the pointers and the level. The other starts or stops the buffer. A status word reports the byte level together with full and empty flags. The byte level is compared against a programmable threshold. Three 6-bit level marks (low, mid and high) are compared against the level counted in entries of the current width. Full, empty and threshold conditions each raise a one-cycle event when they become true. A push into a full buffer gives a one-cycle overflow strobe, and a pop from an empty buffer gives a one-cycle underflow strobe.

Top module: `lvl_fifo`

## Requirements
- R1: After `rst`, the buffer is stopped. `status` reads 0x200: bit 9 is the empty flag, bit 8 is the full flag and bits 7:0 are the byte level. `rdata`, the strobes, the events and the mark flags are all 0.
- R2: Width code 0 stores 1-byte entries (wdata[7:0]). Code 1 stores 2-byte entries (wdata[15:0]). Codes 2 and 3 store 4-byte entries. Popped entries leave in push order, zero-extended to 32 bits on `rdata`. The level field counts stored bytes. The width is changed only together with a clear.
- R3: Capacity is 256 bytes. The full flag is set when fewer free bytes remain than one entry needs, and the level field then shows the byte count modulo 256. A push while full gives a one-cycle `ovf` pulse, and the data and level are unchanged.
- R4: A pop while empty gives a one-cycle `unf` pulse, and `rdata` keeps its last value.
- R5: An operation write with `op_val[1]`=1 starts the buffer, and one with `op_val[1]`=0 stops it. While stopped, pushes and pops are ignored without strobes, and the stored entries are kept for use after a restart.
- R6: An operation write with `op_val[0]`=1 empties the buffer and clears `rdata` to 0. In the cycle of an operation write, push and pop are ignored.
- R7: `thr_hit` is high while the byte level is at least `thresh`. `thr_evt` pulses for one cycle when `thr_hit` rises.
- R8: `full_evt` pulses for one cycle when the full flag sets. `empty_evt` pulses for one cycle when the empty flag sets.
- R9: `sc_hi`, `lc_hi` and `hc_hi` are high while the level, counted in entries of the current width, is at least `mark_sc`, `mark_lc` and `mark_hc` respectively.
- R10: `rdata`, `ovf` and `unf` change on the clock edge that accepts the push or pop. `status`, the threshold flags, the mark flags and the events follow one edge later.
- R11: A push and a pop in the same cycle, while neither full nor empty, leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_wr | input | 1 | Operation write strobe |
| op_val | input | 2 | Bit 0 clears, bit 1 runs |
| wcode | input | 2 | Entry width code |
| thresh | input | 8 | Byte-level threshold |
| mark_sc | input | 6 | Low level mark, in entries |
| mark_lc | input | 6 | Mid level mark, in entries |
| mark_hc | input | 6 | High level mark, in entries |
| push | input | 1 | Push one entry |
| wdata | input | 32 | Push data |
| pop | input | 1 | Pop one entry |
| rdata | output | 32 | Popped entry, zero-extended |
| status | output | 10 | {empty, full, byte level[7:0]} |
| ovf | output | 1 | Overflow strobe |
| unf | output | 1 | Underflow strobe |
| thr_hit | output | 1 | Level at or above threshold |
| thr_evt | output | 1 | Threshold-reached event |
| full_evt | output | 1 | Full event |
| empty_evt | output | 1 | Empty event |
| sc_hi | output | 1 | Entry level at or above low mark |
| lc_hi | output | 1 | Entry level at or above mid mark |
| hc_hi | output | 1 | Entry level at or above high mark |

## Verification
The assertions check several properties on every cycle. A stopped buffer never changes its level, and a clear always empties it. A dropped push leaves the level unchanged, and the byte count never exceeds capacity. `rdata` only changes on an accepted pop or a clear. Full and empty are never set together, and each event coincides with its flag. Only the bench scenarios can show the data itself: byte ordering and zero extension for each width, the exact cycle at which the threshold and the mark flags change, and the wrap-around of the level field at capacity.

// File: rtl/lvl_fifo_pkg.sv
package lvl_fifo_pkg;
  // Log2 of the entry size in bytes: codes 2 and 3 both mean 4 bytes.
  function automatic logic [1:0] width_shift(input logic [1:0] code);
    return code[1] ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/lvl_fifo_ctrl.sv
module lvl_fifo_ctrl
  import lvl_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_wr,
  input  logic [1:0]       op_val,
  input  logic [1:0]       wcode,
  input  logic             push,
  input  logic             pop,
  output logic             we,
  output logic             re,
  output logic             clr,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [1:0]       shift,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             unf
);
  logic             run_q, ovf_q, unf_q;
  logic [CNT_W-1:0] cnt_q, ebytes, free_b;
  logic [PTR_W-1:0] wp_q, rp_q;
  logic             is_full, is_empty, want_push, want_pop, do_push, do_pop;

  always_comb begin
    shift     = width_shift(wcode);
    ebytes    = CNT_W'(1) << shift;
    free_b    = CNT_W'(DEPTH) - cnt_q;
    is_full   = free_b < ebytes;
    is_empty  = cnt_q < ebytes;
    want_push = run_q & ~op_wr & push;
    want_pop  = run_q & ~op_wr & pop;
    do_push   = want_push & ~is_full;
    do_pop    = want_pop & ~is_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= want_push & is_full;
      unf_q <= want_pop & is_empty;
      if (op_wr) begin
        run_q <= op_val[1];
        if (op_val[0]) begin
          cnt_q <= '0;
          wp_q  <= '0;
          rp_q  <= '0;
        end
      end else begin
        if (do_push) wp_q <= wp_q + PTR_W'(ebytes);
        if (do_pop)  rp_q <= rp_q + PTR_W'(ebytes);
        cnt_q <= cnt_q + (do_push ? ebytes : '0) - (do_pop ? ebytes : '0);
      end
    end
  end

  assign we    = do_push;
  assign re    = do_pop;
  assign clr   = op_wr & op_val[0];
  assign wptr  = wp_q;
  assign rptr  = rp_q;
  assign count = cnt_q;
  assign ovf   = ovf_q;
  assign unf   = unf_q;

  // R5: a stopped buffer keeps its level
  p_stopped_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !op_wr) |=> (cnt_q == $past(cnt_q)));
  // R6: clear empties the buffer on the next edge
  p_clear_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (op_wr && op_val[0]) |=> (cnt_q == '0));
  // R3: a dropped push with no pop leaves the level untouched
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (want_push && is_full && !do_pop) |=> (cnt_q == $past(cnt_q)));
  // R3: byte count never exceeds capacity
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/lvl_fifo_store.sv
module lvl_fifo_store #(
  parameter int DEPTH = 256,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LSB_W = $clog2(LANES),
  localparam int ROWS  = DEPTH / LANES,
  localparam int ROW_W = PTR_W - LSB_W,
  localparam int DW    = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic             re,
  input  logic [1:0]       shift,
  input  logic [PTR_W-1:0] wptr,
  input  logic [PTR_W-1:0] rptr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0]    q_all;
  logic [LSB_W-1:0] rd_off, idx;
  logic [1:0]       rd_sh;

  // One byte-wide bank per lane, each inferable as block RAM with an output register.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0]       mem [ROWS];
    logic [7:0]       q_r, din;
    logic [LSB_W-1:0] k;
    logic             lane_we;

    always_comb begin
      k       = LSB_W'(g) - wptr[LSB_W-1:0];
      din     = wdata[{k, 3'b000} +: 8];
      lane_we = we && ({1'b0, k} < ((LSB_W+1)'(1) << shift));
    end

    always_ff @(posedge clk) begin
      if (lane_we) mem[wptr[PTR_W-1:LSB_W]] <= din;
    end

    always_ff @(posedge clk) begin
      if (rst || clr)  q_r <= '0;
      else if (re)     q_r <= mem[rptr[PTR_W-1:LSB_W]];
    end

    assign q_all[8*g +: 8] = q_r;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_off <= '0;
      rd_sh  <= '0;
    end else if (re) begin
      rd_off <= rptr[LSB_W-1:0];
      rd_sh  <= shift;
    end
  end

  always_comb begin
    rdata = '0;
    idx   = '0;
    for (int k = 0; k < LANES; k++) begin
      idx = rd_off + LSB_W'(k);
      if (k < (1 << rd_sh)) rdata[8*k +: 8] = q_all[{idx, 3'b000} +: 8];
    end
  end

  // R6: clear zeroes the read data
  p_clr_zero_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rdata == '0));
  // R4: read data only moves on an accepted pop or a clear
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!re && !clr) |=> $stable(rdata));
endmodule

// File: rtl/lvl_fifo_flags.sv
module lvl_fifo_flags #(
  parameter int DEPTH  = 256,
  parameter int THR_W  = 8,
  parameter int MARK_W = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int ST_W  = PTR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        shift,
  input  logic [THR_W-1:0]  thresh,
  input  logic [MARK_W-1:0] mark_sc,
  input  logic [MARK_W-1:0] mark_lc,
  input  logic [MARK_W-1:0] mark_hc,
  output logic [ST_W-1:0]   status,
  output logic              thr_hit,
  output logic              thr_evt,
  output logic              full_evt,
  output logic              empty_evt,
  output logic              sc_hi,
  output logic              lc_hi,
  output logic              hc_hi
);
  localparam int F_BIT = PTR_W;
  localparam int E_BIT = PTR_W + 1;

  logic [CNT_W-1:0] ebytes, lvl_e;
  logic             full_n, empty_n, thr_n;

  always_comb begin
    ebytes  = CNT_W'(1) << shift;
    full_n  = (CNT_W'(DEPTH) - count) < ebytes;
    empty_n = count < ebytes;
    lvl_e   = count >> shift;
    thr_n   = count >= CNT_W'(thresh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= ST_W'(1) << E_BIT;
      thr_hit   <= 1'b0;
      thr_evt   <= 1'b0;
      full_evt  <= 1'b0;
      empty_evt <= 1'b0;
      sc_hi     <= 1'b0;
      lc_hi     <= 1'b0;
      hc_hi     <= 1'b0;
    end else begin
      status    <= {empty_n, full_n, count[PTR_W-1:0]};
      thr_hit   <= thr_n;
      thr_evt   <= thr_n & ~thr_hit;
      full_evt  <= full_n & ~status[F_BIT];
      empty_evt <= empty_n & ~status[E_BIT];
      sc_hi     <= lvl_e >= CNT_W'(mark_sc);
      lc_hi     <= lvl_e >= CNT_W'(mark_lc);
      hc_hi     <= lvl_e >= CNT_W'(mark_hc);
    end
  end

  // R3: full and empty never together
  p_full_empty_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(status[F_BIT] && status[E_BIT]));
  // R7: a threshold event comes with the threshold flag
  p_thr_evt_flag_r7: assert property (@(posedge clk) disable iff (rst)
    thr_evt |-> thr_hit);
  // R8: full event coincides with the full flag
  p_full_evt_flag_r8: assert property (@(posedge clk) disable iff (rst)
    full_evt |-> status[F_BIT]);
  // R8: empty event coincides with the empty flag
  p_empty_evt_flag_r8: assert property (@(posedge clk) disable iff (rst)
    empty_evt |-> status[E_BIT]);
endmodule

// File: rtl/lvl_fifo.sv
module lvl_fifo #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int THR_W  = 8,
  parameter int MARK_W = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int DW    = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_wr,
  input  logic [1:0]        op_val,
  input  logic [1:0]        wcode,
  input  logic [THR_W-1:0]  thresh,
  input  logic [MARK_W-1:0] mark_sc,
  input  logic [MARK_W-1:0] mark_lc,
  input  logic [MARK_W-1:0] mark_hc,
  input  logic              push,
  input  logic [DW-1:0]     wdata,
  input  logic              pop,
  output logic [DW-1:0]     rdata,
  output logic [PTR_W+1:0]  status,
  output logic              ovf,
  output logic              unf,
  output logic              thr_hit,
  output logic              thr_evt,
  output logic              full_evt,
  output logic              empty_evt,
  output logic              sc_hi,
  output logic              lc_hi,
  output logic              hc_hi
);
  logic             we, re, clr;
  logic [PTR_W-1:0] wptr, rptr;
  logic [1:0]       shift;
  logic [CNT_W-1:0] count;

  lvl_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .op_wr(op_wr), .op_val(op_val), .wcode(wcode),
    .push(push), .pop(pop), .we(we), .re(re), .clr(clr), .wptr(wptr),
    .rptr(rptr), .shift(shift), .count(count), .ovf(ovf), .unf(unf)
  );

  lvl_fifo_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk(clk), .rst(rst), .clr(clr), .we(we), .re(re), .shift(shift),
    .wptr(wptr), .rptr(rptr), .wdata(wdata), .rdata(rdata)
  );

  lvl_fifo_flags #(.DEPTH(DEPTH), .THR_W(THR_W), .MARK_W(MARK_W)) u_flags (
    .clk(clk), .rst(rst), .count(count), .shift(shift), .thresh(thresh),
    .mark_sc(mark_sc), .mark_lc(mark_lc), .mark_hc(mark_hc), .status(status),
    .thr_hit(thr_hit), .thr_evt(thr_evt), .full_evt(full_evt),
    .empty_evt(empty_evt), .sc_hi(sc_hi), .lc_hi(lc_hi), .hc_hi(hc_hi)
  );
endmodule

// File: tb/sim_lvl_fifo.sv
`timescale 1ns/1ps
module sim_lvl_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_wr = 1'b0;
  logic [1:0]  op_val = 2'd0;
  logic [1:0]  wcode = 2'd0;
  logic [7:0]  thresh = 8'd4;
  logic [5:0]  mark_sc = 6'd2, mark_lc = 6'd3, mark_hc = 6'd5;
  logic        push = 1'b0, pop = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  status;
  logic        ovf, unf, thr_hit, thr_evt, full_evt, empty_evt, sc_hi, lc_hi, hc_hi;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lvl_fifo u0 (
    .clk(clk), .rst(rst), .op_wr(op_wr), .op_val(op_val), .wcode(wcode),
    .thresh(thresh), .mark_sc(mark_sc), .mark_lc(mark_lc), .mark_hc(mark_hc),
    .push(push), .wdata(wdata), .pop(pop), .rdata(rdata), .status(status),
    .ovf(ovf), .unf(unf), .thr_hit(thr_hit), .thr_evt(thr_evt),
    .full_evt(full_evt), .empty_evt(empty_evt), .sc_hi(sc_hi), .lc_hi(lc_hi),
    .hc_hi(hc_hi)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic p, input logic q, input logic [31:0] d);
    push = p; pop = q; wdata = d;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic op(input logic [1:0] v);
    op_wr = 1'b1; op_val = v;
    @(negedge clk);
    op_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1", "status", 32'(status), 32'h200);
    chk("R1", "rdata", rdata, 32'h0);
    chk("R1", "strobes+events", {26'd0, ovf, unf, thr_evt, full_evt, empty_evt, thr_hit}, 32'h0);
    chk("R1", "marks", {29'd0, sc_hi, lc_hi, hc_hi}, 32'h0);
  endtask

  task automatic t_byte_order();
    wcode = 2'd0; op(2'b11);
    step(1, 0, 32'hFFFF_FFA1);
    step(1, 0, 32'hFFFF_FFB2);
    step(1, 0, 32'hFFFF_FFC3);
    idle();
    chk("R2", "byte level", 32'(status), 32'h003);
    step(0, 1, '0); chk("R2", "byte pop0", rdata, 32'h0000_00A1);
    step(0, 1, '0); chk("R2", "byte pop1", rdata, 32'h0000_00B2);
    step(0, 1, '0); chk("R2", "byte pop2", rdata, 32'h0000_00C3);
  endtask

  task automatic t_half_order();
    wcode = 2'd1; op(2'b11);
    step(1, 0, 32'h1234_ABCD);
    step(1, 0, 32'h5678_0F0E);
    idle();
    chk("R2", "half level bytes", 32'(status), 32'h004);
    step(0, 1, '0); chk("R2", "half pop0", rdata, 32'h0000_ABCD);
    step(0, 1, '0); chk("R2", "half pop1", rdata, 32'h0000_0F0E);
  endtask

  task automatic t_word_fill();
    wcode = 2'd2; op(2'b11);
    for (int i = 0; i < 64; i++) step(1, 0, 32'hC0DE_0000 + 32'(i));
    idle();
    chk("R3", "full status wraps", 32'(status), 32'h100);
    chk("R8", "full_evt", 32'(full_evt), 32'h1);
    idle();
    chk("R8", "full_evt one cycle", 32'(full_evt), 32'h0);
    step(1, 0, 32'hDEAD_BEEF);
    chk("R3", "ovf pulse", 32'(ovf), 32'h1);
    idle();
    chk("R3", "ovf clears", 32'(ovf), 32'h0);
    chk("R3", "level after ovf", 32'(status), 32'h100);
    for (int i = 0; i < 64; i++) begin
      step(0, 1, '0);
      chk("R2", "word pop", rdata, 32'hC0DE_0000 + 32'(i));
    end
    idle();
    chk("R8", "empty_evt", 32'(empty_evt), 32'h1);
    chk("R3", "drained status", 32'(status), 32'h200);
    step(0, 1, '0);
    chk("R4", "unf pulse", 32'(unf), 32'h1);
    chk("R4", "rdata holds", rdata, 32'hC0DE_003F);
    idle();
    chk("R4", "unf clears", 32'(unf), 32'h0);
  endtask

  task automatic t_stop_keep();
    wcode = 2'd0; op(2'b11);
    step(1, 0, 32'h11);
    step(1, 0, 32'h22);
    op(2'b00);
    step(1, 0, 32'h33);
    chk("R5", "no ovf while stopped", 32'(ovf), 32'h0);
    idle();
    chk("R5", "level kept while stopped", 32'(status), 32'h002);
    step(0, 1, '0);
    chk("R5", "no unf while stopped", 32'(unf), 32'h0);
    chk("R5", "rdata unchanged while stopped", rdata, 32'h0);
    op(2'b10);
    step(0, 1, '0); chk("R5", "kept entry0", rdata, 32'h11);
    step(0, 1, '0); chk("R5", "kept entry1", rdata, 32'h22);
    idle();
    chk("R5", "push while stopped not stored", 32'(status), 32'h200);
  endtask

  task automatic t_clear_priority();
    wcode = 2'd0; op(2'b11);
    step(1, 0, 32'h9A);
    step(1, 0, 32'h9B);
    step(0, 1, '0);
    chk("R6", "pre-clear rdata", rdata, 32'h9A);
    op(2'b11);
    chk("R6", "clear zeroes rdata", rdata, 32'h0);
    idle();
    chk("R6", "clear empties", 32'(status), 32'h200);
    op_wr = 1'b1; op_val = 2'b11; push = 1'b1; wdata = 32'h77;
    @(negedge clk);
    op_wr = 1'b0; push = 1'b0;
    idle();
    chk("R6", "push ignored during op write", 32'(status), 32'h200);
  endtask

  task automatic t_threshold();
    wcode = 2'd0; thresh = 8'd4; op(2'b11);
    for (int i = 0; i < 3; i++) step(1, 0, 32'(i));
    idle();
    chk("R7", "below threshold", {30'd0, thr_hit, thr_evt}, 32'h0);
    step(1, 0, 32'h3);
    chk("R10", "flag lags by one edge", 32'(thr_hit), 32'h0);
    idle();
    chk("R7", "threshold reached", {30'd0, thr_hit, thr_evt}, 32'h3);
    idle();
    chk("R7", "event one cycle", {30'd0, thr_hit, thr_evt}, 32'h2);
  endtask

  task automatic t_marks();
    wcode = 2'd1; op(2'b11);
    for (int i = 0; i < 3; i++) step(1, 0, 32'h100 + 32'(i));
    idle();
    chk("R9", "marks at 3 entries", {29'd0, sc_hi, lc_hi, hc_hi}, 32'h6);
    step(1, 0, 32'h200);
    step(1, 0, 32'h201);
    idle();
    chk("R9", "marks at 5 entries", {29'd0, sc_hi, lc_hi, hc_hi}, 32'h7);
  endtask

  task automatic t_simul();
    wcode = 2'd0; op(2'b11);
    step(1, 0, 32'h55);
    step(1, 1, 32'h66);
    chk("R11", "simul pop data", rdata, 32'h55);
    idle();
    chk("R11", "simul level", 32'(status), 32'h001);
    step(0, 1, '0);
    chk("R11", "simul second entry", rdata, 32'h66);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog got=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle();
    t_reset_state();
    t_byte_order();
    t_half_order();
    t_word_fill();
    t_stop_keep();
    t_clear_priority();
    t_threshold();
    t_marks();
    t_simul();
    summary();
    $finish;
  end
endmodule